// File: doc/BRIEF.md
# Microcontroller GPIO Port Register Block

This block is the register side of one 8-pin general-purpose I/O port on a small microcontroller's special-function-register bus. It holds four per-pin registers: an output data latch, an output driver mode (open-drain or push-pull), an input mode (digital or analog) and a skip mask. From these it drives each pad's output-enable and output value, and it samples the pad inputs through a two-flop synchroniser.

A plain read of the data address returns the synchronised pin levels. A read that the CPU flags as read-modify-write returns the latch contents instead, so logic operations, complement, increment and bit set or clear do not pick up a pin that an external load holds low. Two designated pins, the two-wire bus data and clock, stay open-drain whatever their mode bits hold. The skip mask is stored and exported only. The routing logic that uses it lies outside this block.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the data latch reads back as all ones. The output mode, input mode and skip registers read back as 0. The synchronised pin view is 0.
- R2: A read of the data address (0x80) with `sfr_rmw` low returns the pad levels sampled through two flops. A change on `pad_in` becomes visible at the second rising clock edge after it, not at the first.
- R3: A read of the data address with `sfr_rmw` high returns the output latch contents, whatever the pins carry.
- R4: A byte write (`sfr_wr`) to the data (0x80), output mode (0xA4), input mode (0xF1) or skip (0xD4) address stores `sfr_wdata` at the next clock edge. A read of that address then returns it.
- R5: A bit write (`bit_wr`) to the data address sets latch bit `bit_idx` to `bit_val` at the next edge and leaves the other seven bits unchanged. A bit write to any other address changes no register.
- R6: With output mode bit 0 (open-drain), a pin has `pad_oe` = NOT latch and `pad_out` = 0. With bit 1 (push-pull), it has `pad_oe` = 1 and `pad_out` = latch.
- R7: With input mode bit 1 (analog), a pin has `pad_oe` = 0 and `pad_out` = 0, and its bit reads as 0 on a plain data read.
- R8: Pins 0 and 1, the bits set in `FORCE_OD_MASK` (default 0x03), behave as open-drain whatever their output mode bits hold.
- R9: `skip_mask` always equals the skip register contents.
- R10: `sfr_rdata` is 0 when `sfr_rd` is low or the address matches none of the four registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Register address |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_wdata | input | 8 | Byte write data |
| sfr_rd | input | 1 | Read strobe |
| sfr_rmw | input | 1 | Read belongs to a read-modify-write access |
| bit_wr | input | 1 | Single-bit write strobe |
| bit_idx | input | 3 | Bit selected by a bit write |
| bit_val | input | 1 | Value for the selected bit |
| sfr_rdata | output | 8 | Read data |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad output enable per pin |
| pad_out | output | 8 | Pad output value per pin |
| skip_mask | output | 8 | Per-pin skip flags for routing logic |

## Verification
The bench builds the block with its default parameters: eight pins, the four addresses above, reset values of zero and a forced open-drain mask of 0x03. With that mask, one push-pull write of 0xFF exercises, in a single pad pattern, both forced pins and six pins that honour their mode bits. With an input mode of 0xF0, analog and digital pins stand side by side, so one read shows the masking of the analog bits next to the pin values. One latch value also covers push-pull pins, open-drain pins and analog pins at once.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Register selected by the current bus address
  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_DATA  = 3'd1,
    TGT_OMODE = 3'd2,
    TGT_IMODE = 3'd3,
    TGT_SKIP  = 3'd4
  } gpio_tgt_e;

  // Output enable of one pad from its latch bit and modes
  function automatic logic pad_enable(input logic latch, input logic push_pull,
                                      input logic analog);
    logic en;
    if (analog) en = 1'b0;
    else if (push_pull) en = 1'b1;
    else en = ~latch;
    return en;
  endfunction

  // Output value of one pad: only a push-pull digital pin drives high
  function automatic logic pad_level(input logic latch, input logic push_pull,
                                     input logic analog);
    return latch & push_pull & ~analog;
  endfunction

  // Merge a single-bit update into one register bit
  function automatic logic bit_merge(input logic old_bit, input logic hit,
                                     input logic new_bit);
    return hit ? new_bit : old_bit;
  endfunction

endpackage

// File: rtl/gpio_sfr_decode.sv
module gpio_sfr_decode
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 'h80,
  parameter logic [ADDR_W-1:0] OMODE_ADDR = 'hA4,
  parameter logic [ADDR_W-1:0] IMODE_ADDR = 'hF1,
  parameter logic [ADDR_W-1:0] SKIP_ADDR  = 'hD4
) (
  input  logic [ADDR_W-1:0] addr,
  output gpio_tgt_e         tgt
);

  always_comb begin
    if (addr == DATA_ADDR) tgt = TGT_DATA;
    else if (addr == OMODE_ADDR) tgt = TGT_OMODE;
    else if (addr == IMODE_ADDR) tgt = TGT_IMODE;
    else if (addr == SKIP_ADDR) tgt = TGT_SKIP;
    else tgt = TGT_NONE;
  end

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pin_sync
);

  logic [NPINS-1:0] stage1_q;
  logic [NPINS-1:0] stage2_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q[i] <= 1'b0;
        stage2_q[i] <= 1'b0;
      end else begin
        stage1_q[i] <= pad_in[i];
        stage2_q[i] <= stage1_q[i];
      end
    end
  end

  assign pin_sync = stage2_q;

  // Cycles since reset, saturating, so the latency check never looks before reset
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= 2'd0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R2
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (pin_sync == $past(pad_in, 2)));

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 8,
  parameter logic [NPINS-1:0] FORCE_OD_MASK = 'h03
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] latch,
  input  logic [NPINS-1:0] omode,
  input  logic [NPINS-1:0] imode,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out
);

  logic [NPINS-1:0] push_pull;

  for (genvar i = 0; i < NPINS; i++) begin : g_drv
    if (FORCE_OD_MASK[i]) begin : g_forced
      assign push_pull[i] = 1'b0;
    end else begin : g_moded
      assign push_pull[i] = omode[i];
    end
    assign pad_oe[i]  = pad_enable(latch[i], push_pull[i], imode[i]);
    assign pad_out[i] = pad_level(latch[i], push_pull[i], imode[i]);
  end

  // R7
  analog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & imode) == '0) && ((pad_out & imode) == '0));

  // R8
  forced_od_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & FORCE_OD_MASK) == '0) &&
    ((pad_oe & FORCE_OD_MASK & ~imode) == (~latch & FORCE_OD_MASK & ~imode)));

  // R6
  drive_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & ~pad_oe) == '0) && ((pad_out & ~latch) == '0));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 'h80,
  parameter logic [ADDR_W-1:0] OMODE_ADDR = 'hA4,
  parameter logic [ADDR_W-1:0] IMODE_ADDR = 'hF1,
  parameter logic [ADDR_W-1:0] SKIP_ADDR  = 'hD4,
  parameter logic [NPINS-1:0]  FORCE_OD_MASK = 'h03,
  parameter logic [NPINS-1:0]  OMODE_RST = '0,
  parameter logic [NPINS-1:0]  IMODE_RST = '0,
  parameter logic [NPINS-1:0]  SKIP_RST  = '0,
  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [NPINS-1:0]  sfr_wdata,
  input  logic              sfr_rd,
  input  logic              sfr_rmw,
  input  logic              bit_wr,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              bit_val,
  output logic [NPINS-1:0]  sfr_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  skip_mask
);

  localparam logic [NPINS-1:0] ONE_HOT0 = {{(NPINS-1){1'b0}}, 1'b1};

  gpio_tgt_e        tgt;
  logic [NPINS-1:0] data_q, data_d;
  logic [NPINS-1:0] omode_q, imode_q, skip_q;
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] pin_view;
  logic [NPINS-1:0] bit_sel;

  // Named write events for the checks
  logic byte_wr_data, byte_wr_omode, byte_wr_imode, byte_wr_skip;
  logic bit_wr_data, bit_wr_elsewhere;

  gpio_sfr_decode #(
    .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .OMODE_ADDR(OMODE_ADDR),
    .IMODE_ADDR(IMODE_ADDR), .SKIP_ADDR(SKIP_ADDR)
  ) u_decode (
    .addr(sfr_addr),
    .tgt (tgt)
  );

  assign byte_wr_data     = sfr_wr && (tgt == TGT_DATA);
  assign byte_wr_omode    = sfr_wr && (tgt == TGT_OMODE);
  assign byte_wr_imode    = sfr_wr && (tgt == TGT_IMODE);
  assign byte_wr_skip     = sfr_wr && (tgt == TGT_SKIP);
  assign bit_wr_data      = bit_wr && !sfr_wr && (tgt == TGT_DATA);
  assign bit_wr_elsewhere = bit_wr && !sfr_wr && (tgt != TGT_DATA);

  // Per-bit selection for the single-bit write path
  for (genvar i = 0; i < NPINS; i++) begin : g_bitsel
    assign bit_sel[i] = bit_wr_data && (bit_idx == IDX_W'(i));
  end

  // Next latch value: a byte write wins over a bit write in the same cycle
  always_comb begin
    data_d = data_q;
    if (byte_wr_data) begin
      data_d = sfr_wdata;
    end else begin
      for (int i = 0; i < NPINS; i++) begin
        data_d[i] = bit_merge(data_q[i], bit_sel[i], bit_val);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '1;
      omode_q <= OMODE_RST;
      imode_q <= IMODE_RST;
      skip_q  <= SKIP_RST;
    end else begin
      data_q <= data_d;
      if (byte_wr_omode) omode_q <= sfr_wdata;
      if (byte_wr_imode) imode_q <= sfr_wdata;
      if (byte_wr_skip)  skip_q  <= sfr_wdata;
    end
  end

  gpio_pin_sync #(.NPINS(NPINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pad_in  (pad_in),
    .pin_sync(pin_sync)
  );

  // Analog pins read as 0 on the digital path
  assign pin_view = pin_sync & ~imode_q;

  gpio_pad_drive #(.NPINS(NPINS), .FORCE_OD_MASK(FORCE_OD_MASK)) u_drive (
    .clk    (clk),
    .rst_n  (rst_n),
    .latch  (data_q),
    .omode  (omode_q),
    .imode  (imode_q),
    .pad_oe (pad_oe),
    .pad_out(pad_out)
  );

  always_comb begin
    sfr_rdata = '0;
    if (sfr_rd) begin
      case (tgt)
        TGT_DATA:  sfr_rdata = sfr_rmw ? data_q : pin_view;
        TGT_OMODE: sfr_rdata = omode_q;
        TGT_IMODE: sfr_rdata = imode_q;
        TGT_SKIP:  sfr_rdata = skip_q;
        default:   sfr_rdata = '0;
      endcase
    end
  end

  assign skip_mask = skip_q;

  // R2
  plain_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd && !sfr_rmw && (sfr_addr == DATA_ADDR)) |-> (sfr_rdata == (pin_sync & ~imode_q)));

  // R3
  rmw_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd && sfr_rmw && (sfr_addr == DATA_ADDR)) |-> (sfr_rdata == data_q));

  // R4
  byte_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_wr_data |=> (data_q == $past(sfr_wdata)));

  // R5
  bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_wr_data |=> (data_q[$past(bit_idx)] == $past(bit_val)));

  // R5
  bit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_wr_data |=> (((data_q ^ $past(data_q)) & ~(ONE_HOT0 << $past(bit_idx))) == '0));

  // R5
  bit_elsewhere_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_wr_elsewhere |=> ($stable(data_q) && $stable(omode_q) && $stable(imode_q) && $stable(skip_q)));

  // R10
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sfr_rd || (tgt == TGT_NONE)) |-> (sfr_rdata == '0));

endmodule

// File: tb/gpio_port_regs_tb.sv
module gpio_port_regs_tb;

  localparam logic [7:0] A_DATA  = 8'h80;
  localparam logic [7:0] A_OMODE = 8'hA4;
  localparam logic [7:0] A_IMODE = 8'hF1;
  localparam logic [7:0] A_SKIP  = 8'hD4;
  localparam logic [7:0] FORCED  = 8'h03;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sfr_addr = '0;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_wdata = '0;
  logic       sfr_rd = 1'b0;
  logic       sfr_rmw = 1'b0;
  logic       bit_wr = 1'b0;
  logic [2:0] bit_idx = '0;
  logic       bit_val = 1'b0;
  logic [7:0] sfr_rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_oe, pad_out, skip_mask;

  always #4 clk = ~clk;

  gpio_port_regs u_dut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rd(sfr_rd), .sfr_rmw(sfr_rmw),
    .bit_wr(bit_wr), .bit_idx(bit_idx), .bit_val(bit_val),
    .sfr_rdata(sfr_rdata), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .skip_mask(skip_mask)
  );

  // Scoreboard item: which output, the expected value, the requirement
  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } sb_item_t;

  sb_item_t sb_q[$];
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Reference state kept by the bench
  logic [7:0] m_data = 8'hFF;
  logic [7:0] m_omode = '0;
  logic [7:0] m_imode = '0;
  logic [7:0] m_skip = '0;
  logic [7:0] m_pins = '0;

  function automatic logic [7:0] ref_oe();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (m_imode[i]) r[i] = 1'b0;
      else if (m_omode[i] && !FORCED[i]) r[i] = 1'b1;
      else r[i] = !m_data[i];
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_out();
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = !m_imode[i] && m_omode[i] && !FORCED[i] && m_data[i];
    return r;
  endfunction

  // Monitor: compares queued items against the outputs at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      sb_item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0: act = sfr_rdata;
        1: act = pad_oe;
        2: act = pad_out;
        default: act = skip_mask;
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(posedge clk); #1;
    sfr_wr = 1'b0;
    if (a == A_DATA) m_data = d;
    else if (a == A_OMODE) m_omode = d;
    else if (a == A_IMODE) m_imode = d;
    else if (a == A_SKIP) m_skip = d;
  endtask

  task automatic do_bit(input logic [7:0] a, input int idx, input logic v);
    @(posedge clk); #1;
    sfr_addr = a; bit_idx = 3'(idx); bit_val = v; bit_wr = 1'b1;
    @(posedge clk); #1;
    bit_wr = 1'b0;
    if (a == A_DATA) m_data[idx] = v;
  endtask

  task automatic expect_read(input logic [7:0] a, input logic rd, input logic rmw,
                             input logic [7:0] e, input string req);
    @(posedge clk); #1;
    sfr_addr = a; sfr_rd = rd; sfr_rmw = rmw;
    sb_q.push_back('{0, e, req});
    @(negedge clk); #1;
    sfr_rd = 1'b0; sfr_rmw = 1'b0;
  endtask

  task automatic expect_pads(input string req);
    @(posedge clk); #1;
    sb_q.push_back('{1, ref_oe(), req});
    sb_q.push_back('{2, ref_out(), req});
    sb_q.push_back('{3, m_skip, req});
    @(negedge clk); #1;
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(posedge clk); #1;
    pad_in = v;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset contents
    expect_read(A_DATA, 1'b1, 1'b1, 8'hFF, "R1 latch");
    expect_read(A_OMODE, 1'b1, 1'b0, 8'h00, "R1 omode");
    expect_read(A_IMODE, 1'b1, 1'b0, 8'h00, "R1 imode");
    expect_read(A_SKIP, 1'b1, 1'b0, 8'h00, "R1 skip");
    expect_read(A_DATA, 1'b1, 1'b0, 8'h00, "R1 pins");
    expect_pads("R1 R6 pads");

    // R4 / R6: byte write to the latch, open-drain drive
    do_write(A_DATA, 8'h5A);
    expect_pads("R6 open-drain");
    expect_read(A_DATA, 1'b1, 1'b1, m_data, "R3 R4 latch");

    // R2: two-edge latency on the pin path
    set_pins(8'h3C);
    expect_read(A_DATA, 1'b1, 1'b0, m_pins, "R2 first edge");
    m_pins = 8'h3C;
    expect_read(A_DATA, 1'b1, 1'b0, m_pins, "R2 second edge");
    expect_read(A_DATA, 1'b1, 1'b1, m_data, "R3 latch not pins");

    // R6 / R8: push-pull except forced pins
    do_write(A_OMODE, 8'hFF);
    expect_read(A_OMODE, 1'b1, 1'b0, m_omode, "R4 omode");
    expect_pads("R6 R8 push-pull");

    // R7: analog upper nibble
    do_write(A_IMODE, 8'hF0);
    expect_read(A_IMODE, 1'b1, 1'b0, m_imode, "R4 imode");
    expect_pads("R7 analog drive");
    expect_read(A_DATA, 1'b1, 1'b0, m_pins & ~m_imode, "R7 analog read");
    expect_read(A_DATA, 1'b1, 1'b1, m_data, "R3 with analog");

    // R5: single-bit writes
    do_bit(A_DATA, 0, 1'b1);
    expect_read(A_DATA, 1'b1, 1'b1, m_data, "R5 set bit0");
    do_bit(A_DATA, 6, 1'b0);
    expect_read(A_DATA, 1'b1, 1'b1, m_data, "R5 clear bit6");
    expect_pads("R5 R6 pads after bits");
    do_bit(A_OMODE, 2, 1'b0);
    expect_read(A_OMODE, 1'b1, 1'b0, m_omode, "R5 elsewhere omode");
    expect_read(A_DATA, 1'b1, 1'b1, m_data, "R5 elsewhere latch");
    expect_pads("R5 elsewhere pads");

    // R9: skip mask
    do_write(A_SKIP, 8'h81);
    expect_read(A_SKIP, 1'b1, 1'b0, m_skip, "R9 skip read");
    expect_pads("R9 skip export");

    // R10: idle and unmapped reads
    expect_read(8'h55, 1'b1, 1'b0, 8'h00, "R10 unmapped");
    expect_read(A_DATA, 1'b0, 1'b1, 8'h00, "R10 no strobe");

    // R8: forced pins stay open-drain with digital inputs and latch low
    do_write(A_IMODE, 8'h00);
    do_write(A_DATA, 8'hA4);
    expect_pads("R8 forced low drive");

    @(posedge clk);
    @(negedge clk);
    #1;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog all-requirements actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule